// File: doc/BRIEF.md
# SPI Flash Manual-Mode Sequencer

This block lets software run one single-lane transaction on a SPI NOR flash at a time. Software fills a small register bank: which phases run, the command byte, a 24-bit address, a dummy clock count and a 32-bit write word. It then writes the start bit. The engine asserts chip select, waits a programmable setup time and clocks out the enabled phases in a fixed order. At the end it holds select for a programmable time, releases it and waits an idle gap before it accepts the next start.

Each phase is optional. A transfer can be a bare command, a command with an address, a read with dummy clocks, or a data-only word. The data phase can send a word, capture a word, or do both at once. A keep-select control leaves chip select low after the transfer. The next start then extends the same frame with data words only, which lets software stream several words under one select.

SCK runs at half the system clock in SPI mode 0 and idles low. Chip select is active low.

Top module: `spiflash_seq`

## Requirements
- R1: After reset, spi_cs_n is 1 and spi_sck and spi_mosi are 0. The status register (offset 7) and the read data register (offset 6) read 0.
- R2: Register offsets on reg_addr: 0 control, 1 phase enable, 2 command, 3 address, 4 dummy count, 5 write data, 6 read data, 7 status, 8 select timing. A write of 1 to control bit 0 while idle starts a transfer from a released select. spi_cs_n falls in the following cycle and then stays low with SCK low for setup+1 cycles, where setup is timing bits 2:0.
- R3: Each bit takes two system cycles, the first with SCK low and the second with SCK high. MOSI holds the bit over both cycles. SCK is low outside bit periods, and MOSI is 0 whenever no command, address or write bit is being sent.
- R4: Phase-enable bit 14 sends the command byte (command register bits 23:16) as 8 bits, most significant bit first.
- R5: A nonzero phase-enable field at bits 11:8 sends address register bits 23:0 as 24 bits, most significant bit first.
- R6: Phase-enable bit 15 adds (dummy register value + 1) clocks with MOSI low.
- R7: A nonzero phase-enable field at bits 3:0 runs a 32-clock data phase when control bit 1 (write) or bit 2 (read) is set. With write set, the write data register is sent starting with byte 0 (bits 7:0), each byte most significant bit first. Without write, MOSI stays low.
- R8: With control bit 2 set, MISO is sampled on each rising SCK edge of the data phase. The first received byte lands in read-data bits 7:0 and the fourth in bits 31:24, each byte with its first bit in the most significant position. Without bit 2, the read data register is left unchanged.
- R9: Enabled phases always run in the order command, address, dummy, data, and disabled phases are skipped. With nothing enabled, no SCK pulse occurs.
- R10: After the last bit, chip select stays low for hold+1 cycles (timing bits 10:8). It is then released and stays high for gap+1 cycles (timing bits 18:16) before a new start is accepted.
- R11: With control bit 8 (keep-select) set, chip select stays low after the last bit and no hold or gap follows. A start made while select is held skips the setup wait and the command, address and dummy phases, and runs only the data phase.
- R12: Status bit 0 is 0 from the start until the last bit of the transfer has completed, and 1 afterwards. Status bit 1 is 1 exactly when chip select is low.
- R13: A control write while a transfer is in progress has no effect: the waveform continues unchanged, and the control fields keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register offset for write and readback |
| reg_wdata | input | 32 | Register write value |
| reg_rdata | output | 32 | Readback of the register at reg_addr |
| spi_sck | output | 1 | Serial clock, idles low |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |

## Verification
A wrong phase selection or bit counter appears on the pins within one bit period, as a misplaced SCK pulse or a wrong MOSI level. For that reason the bench compares chip select, SCK and MOSI against its own expected waveform on every cycle. A wrong shift direction or byte order in the receive path shows only when the read data register is read after the transfer. A wrong keep-select state shows up one cycle after the last bit, as a select release that should not happen or a missing one.

// File: rtl/spiflash_seq_pkg.sv
`timescale 1ns/1ps
package spiflash_seq_pkg;
    localparam int RA_W   = 4;
    localparam int WORD_W = 32;
    localparam int DMY_W  = 8;
    localparam int DLY_W  = 3;
    localparam int CNT_W  = (DMY_W > 5) ? DMY_W : 5;

    localparam logic [RA_W-1:0] RA_CTRL = 4'd0;
    localparam logic [RA_W-1:0] RA_PHEN = 4'd1;
    localparam logic [RA_W-1:0] RA_CMD  = 4'd2;
    localparam logic [RA_W-1:0] RA_ADDR = 4'd3;
    localparam logic [RA_W-1:0] RA_DMY  = 4'd4;
    localparam logic [RA_W-1:0] RA_WDAT = 4'd5;
    localparam logic [RA_W-1:0] RA_RDAT = 4'd6;
    localparam logic [RA_W-1:0] RA_STAT = 4'd7;
    localparam logic [RA_W-1:0] RA_DLY  = 4'd8;

    typedef enum logic [2:0] {ST_IDLE, ST_SETUP, ST_SHIFT, ST_HOLD, ST_GAP} seq_state_e;
    typedef enum logic [1:0] {PH_CMD, PH_ADDR, PH_DMY, PH_DATA} phase_e;

    typedef struct packed {
        logic              cmd_en;
        logic              addr_en;
        logic              dmy_en;
        logic              data_en;
        logic              wr_en;
        logic              rd_en;
        logic              keep;
        logic [7:0]        cmd;
        logic [23:0]       addr;
        logic [DMY_W-1:0]  dmy_m1;
        logic [WORD_W-1:0] wdata;
        logic [DLY_W-1:0]  setup;
        logic [DLY_W-1:0]  hold;
        logic [DLY_W-1:0]  gap;
    } seq_cfg_t;

    function automatic logic [WORD_W-1:0] byte_swap(input logic [WORD_W-1:0] v);
        logic [WORD_W-1:0] r;
        for (int b = 0; b < WORD_W/8; b++)
            r[b*8 +: 8] = v[WORD_W-8-b*8 +: 8];
        return r;
    endfunction
endpackage

// File: rtl/spiflash_seq_regs.sv
`timescale 1ns/1ps
module spiflash_seq_regs
    import spiflash_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [RA_W-1:0]   reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    input  logic              busy_i,
    input  logic              tend_i,
    input  logic              cs_act_i,
    input  logic [WORD_W-1:0] rdata_i,
    output seq_cfg_t          cfg_o,
    output logic              start_o
);
    typedef struct packed {
        logic              wr;
        logic              rd;
        logic              keep;
        logic [15:0]       phen;
        logic [7:0]        cmd;
        logic [23:0]       addr;
        logic [DMY_W-1:0]  dmy;
        logic [WORD_W-1:0] wdat;
        logic [DLY_W-1:0]  setup;
        logic [DLY_W-1:0]  hold;
        logic [DLY_W-1:0]  gap;
    } regs_t;

    regs_t q, d;
    logic  ctrl_acc;

    always_comb begin
        d        = q;
        ctrl_acc = reg_we && (reg_addr == RA_CTRL) && !busy_i;
        start_o  = ctrl_acc && reg_wdata[0];
        if (ctrl_acc) begin
            d.wr   = reg_wdata[1];
            d.rd   = reg_wdata[2];
            d.keep = reg_wdata[8];
        end
        if (reg_we) begin
            case (reg_addr)
                RA_PHEN: d.phen = reg_wdata[15:0] & 16'hCF0F;
                RA_CMD:  d.cmd  = reg_wdata[23:16];
                RA_ADDR: d.addr = reg_wdata[23:0];
                RA_DMY:  d.dmy  = reg_wdata[DMY_W-1:0];
                RA_WDAT: d.wdat = reg_wdata;
                RA_DLY: begin
                    d.setup = reg_wdata[0 +: DLY_W];
                    d.hold  = reg_wdata[8 +: DLY_W];
                    d.gap   = reg_wdata[16 +: DLY_W];
                end
                default: ;
            endcase
        end

        cfg_o.cmd_en  = d.phen[14];
        cfg_o.addr_en = |d.phen[11:8];
        cfg_o.dmy_en  = d.phen[15];
        cfg_o.data_en = |d.phen[3:0];
        cfg_o.wr_en   = d.wr;
        cfg_o.rd_en   = d.rd;
        cfg_o.keep    = d.keep;
        cfg_o.cmd     = d.cmd;
        cfg_o.addr    = d.addr;
        cfg_o.dmy_m1  = d.dmy;
        cfg_o.wdata   = d.wdat;
        cfg_o.setup   = d.setup;
        cfg_o.hold    = d.hold;
        cfg_o.gap     = d.gap;

        reg_rdata = '0;
        case (reg_addr)
            RA_CTRL: begin
                reg_rdata[1] = q.wr;
                reg_rdata[2] = q.rd;
                reg_rdata[8] = q.keep;
            end
            RA_PHEN: reg_rdata[15:0] = q.phen;
            RA_CMD:  reg_rdata[23:16] = q.cmd;
            RA_ADDR: reg_rdata[23:0] = q.addr;
            RA_DMY:  reg_rdata[DMY_W-1:0] = q.dmy;
            RA_WDAT: reg_rdata = q.wdat;
            RA_RDAT: reg_rdata = rdata_i;
            RA_STAT: reg_rdata[1:0] = {cs_act_i, tend_i};
            RA_DLY: begin
                reg_rdata[0 +: DLY_W]  = q.setup;
                reg_rdata[8 +: DLY_W]  = q.hold;
                reg_rdata[16 +: DLY_W] = q.gap;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R13: control fields frozen while a transfer runs
    a_r13_ctrl_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |=> $stable({q.wr, q.rd, q.keep}));
endmodule

// File: rtl/spiflash_seq_core.sv
`timescale 1ns/1ps
module spiflash_seq_core
    import spiflash_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  seq_cfg_t          cfg_i,
    input  logic              miso_i,
    output logic              sck_o,
    output logic              mosi_o,
    output logic              cs_n_o,
    output logic              busy_o,
    output logic              tend_o,
    output logic [WORD_W-1:0] rdata_o
);
    typedef struct packed {
        seq_state_e        st;
        phase_e            ph;
        logic              half;
        logic [CNT_W-1:0]  cnt;
        logic [WORD_W-1:0] sh;
        logic              cs_n;
        logic              tend;
        logic [WORD_W-1:0] rdata;
    } core_t;

    core_t q, d;

    function automatic logic [2:0] first_phase(input logic [3:0] act, input logic [2:0] from);
        logic [2:0] r;
        r = 3'b000;
        for (int i = 3; i >= 0; i--)
            if (act[i] && (i >= int'(from))) r = {1'b1, 2'(i)};
        return r;
    endfunction

    always_comb begin
        logic [3:0]        act;
        logic              want;
        logic [2:0]        from;
        logic [2:0]        pick;
        logic [WORD_W-1:0] sh_in;
        d     = q;
        want  = 1'b0;
        from  = 3'd0;
        act   = {cfg_i.data_en & (cfg_i.wr_en | cfg_i.rd_en), cfg_i.dmy_en,
                 cfg_i.addr_en, cfg_i.cmd_en};
        sh_in = {q.sh[WORD_W-2:0], miso_i};
        case (q.st)
            ST_IDLE: if (start_i) begin
                d.tend = 1'b0;
                if (!q.cs_n) begin
                    want = 1'b1;
                    from = 3'd3;
                end else begin
                    d.cs_n = 1'b0;
                    d.st   = ST_SETUP;
                    d.cnt  = CNT_W'(cfg_i.setup);
                end
            end
            ST_SETUP: if (q.cnt == '0) want = 1'b1;
                      else d.cnt = q.cnt - 1'b1;
            ST_SHIFT: if (!q.half) d.half = 1'b1;
            else begin
                d.half = 1'b0;
                d.sh   = sh_in;
                if (q.cnt == '0) begin
                    if (q.ph == PH_DATA && cfg_i.rd_en) d.rdata = byte_swap(sh_in);
                    want = 1'b1;
                    from = {1'b0, q.ph} + 3'd1;
                end else d.cnt = q.cnt - 1'b1;
            end
            ST_HOLD: if (q.cnt == '0) begin
                d.cs_n = 1'b1;
                d.st   = ST_GAP;
                d.cnt  = CNT_W'(cfg_i.gap);
            end else d.cnt = q.cnt - 1'b1;
            ST_GAP: if (q.cnt == '0) d.st = ST_IDLE;
                    else d.cnt = q.cnt - 1'b1;
            default: d.st = ST_IDLE;
        endcase

        pick = first_phase(act, from);
        if (want) begin
            if (pick[2]) begin
                d.st   = ST_SHIFT;
                d.half = 1'b0;
                d.ph   = phase_e'(pick[1:0]);
                case (phase_e'(pick[1:0]))
                    PH_CMD:  begin d.sh = {cfg_i.cmd, 24'd0};  d.cnt = CNT_W'(7);  end
                    PH_ADDR: begin d.sh = {cfg_i.addr, 8'd0};  d.cnt = CNT_W'(23); end
                    PH_DMY:  begin d.sh = '0; d.cnt = CNT_W'(cfg_i.dmy_m1); end
                    default: begin d.sh = byte_swap(cfg_i.wdata); d.cnt = CNT_W'(WORD_W-1); end
                endcase
            end else begin
                d.tend = 1'b1;
                if (cfg_i.keep) d.st = ST_IDLE;
                else begin
                    d.st  = ST_HOLD;
                    d.cnt = CNT_W'(cfg_i.hold);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= ST_IDLE;
            q.ph   <= PH_CMD;
            q.cs_n <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign sck_o   = (q.st == ST_SHIFT) && q.half;
    assign mosi_o  = (q.st == ST_SHIFT) && (q.ph != PH_DMY) &&
                     !(q.ph == PH_DATA && !cfg_i.wr_en) && q.sh[WORD_W-1];
    assign cs_n_o  = q.cs_n;
    assign busy_o  = (q.st != ST_IDLE);
    assign tend_o  = q.tend;
    assign rdata_o = q.rdata;

    // R3: clock pulses only inside a select frame, one cycle high each
    a_r3_sck_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        sck_o |-> !cs_n_o);
    a_r3_sck_one_high: assert property (@(posedge clk) disable iff (!rst_n)
        sck_o |=> !sck_o);
    a_r3_mosi_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_o |-> !mosi_o);
    // R13: the register bank never passes a start through while busy
    a_r13_no_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !start_i);
    // R12: transfer-end drops only because of a start
    a_r12_tend_falls_on_start: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tend_o) |-> $past(start_i));
    // R10: select released only at the end of the hold time
    a_r10_release_after_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n_o) |-> $past(q.st == ST_HOLD));
endmodule

// File: rtl/spiflash_seq.sv
`timescale 1ns/1ps
module spiflash_seq
    import spiflash_seq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [3:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        spi_sck,
    output logic        spi_cs_n,
    output logic        spi_mosi,
    input  logic        spi_miso
);
    seq_cfg_t          cfg;
    logic              start;
    logic              busy;
    logic              tend;
    logic [WORD_W-1:0] rdata;

    spiflash_seq_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .busy_i    (busy),
        .tend_i    (tend),
        .cs_act_i  (!spi_cs_n),
        .rdata_i   (rdata),
        .cfg_o     (cfg),
        .start_o   (start)
    );

    spiflash_seq_core u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start),
        .cfg_i   (cfg),
        .miso_i  (spi_miso),
        .sck_o   (spi_sck),
        .mosi_o  (spi_mosi),
        .cs_n_o  (spi_cs_n),
        .busy_o  (busy),
        .tend_o  (tend),
        .rdata_o (rdata)
    );
endmodule

// File: tb/spiflash_seq_tb.sv
`timescale 1ns/1ps
module spiflash_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = 4'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        spi_sck, spi_cs_n, spi_mosi;
    logic        spi_miso = 1'b0;

    spiflash_seq u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_sck(spi_sck),
        .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    always #10 clk = ~clk;

    int          checks = 0;
    int          errors = 0;
    bit          done = 0;
    logic [2:0]  expq[$];
    logic        idle_cs_n = 1'b1;
    int          setup_c = 0, hold_c = 0, gap_c = 0, m_dmy = 0;
    logic [7:0]  m_cmd = 8'd0;
    logic [23:0] m_addr = 24'd0;
    logic [31:0] m_wdata = 32'd0;
    logic        en_cmd = 0, en_addr = 0, en_dmy = 0, en_data = 0;
    logic [63:0] pat = 64'hC3A5_0F96_7E18_D24B;
    int          rxcnt = 0;
    logic        prev_sck = 1'b0;
    int          frame_bits = 0;
    logic [31:0] exp_rdata = 32'd0;
    logic [31:0] v;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one cycle: compare pins with the reference waveform, then update the flash model
    task automatic tick(input string req);
        logic [2:0] e;
        @(negedge clk);
        e = (expq.size() > 0) ? expq.pop_front() : {idle_cs_n, 2'b00};
        check(req, {29'd0, spi_cs_n, spi_sck, spi_mosi}, {29'd0, e});
        if (spi_cs_n) rxcnt = 0;
        else if (prev_sck && !spi_sck) rxcnt++;
        prev_sck = spi_sck;
        spi_miso = pat[63 - (rxcnt % 64)];
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] val, input string req);
        reg_we = 1'b1; reg_addr = a; reg_wdata = val;
        tick(req);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] val);
        reg_we = 1'b0; reg_addr = a;
        #1;
        val = reg_rdata;
    endtask

    task automatic set_delays(input int s, input int h, input int g);
        setup_c = s; hold_c = h; gap_c = g;
        wr(4'd8, 32'((g << 16) | (h << 8) | s), "R2 timing write");
    endtask

    task automatic set_phases(input logic c, input logic a, input logic dm, input logic da);
        en_cmd = c; en_addr = a; en_dmy = dm; en_data = da;
        wr(4'd1, {16'd0, dm, c, 2'b00, (a ? 4'h7 : 4'h0), 4'h0, (da ? 4'hF : 4'h0)}, "R2 enable write");
    endtask

    task automatic push_bit(input logic b);
        expq.push_back({2'b00, b});
        expq.push_back({2'b01, b});
    endtask

    task automatic xfer(input logic w, input logic r, input logic keep,
                        input int inject, input string req);
        bit cont;
        bit dact;
        int off;
        int n;
        cont = (idle_cs_n == 1'b0);
        dact = en_data && (w || r);
        off  = frame_bits;
        if (!cont) begin
            repeat (setup_c + 1) expq.push_back(3'b000);
            if (en_cmd)  begin for (int k = 0; k < 8; k++)  push_bit(m_cmd[7-k]);  off += 8;  end
            if (en_addr) begin for (int k = 0; k < 24; k++) push_bit(m_addr[23-k]); off += 24; end
            if (en_dmy)  begin for (int k = 0; k <= m_dmy; k++) push_bit(1'b0); off += m_dmy + 1; end
        end
        if (dact) begin
            for (int k = 0; k < 32; k++) begin
                push_bit(w ? m_wdata[(k/8)*8 + 7 - (k%8)] : 1'b0);
                if (r) exp_rdata[(k/8)*8 + 7 - (k%8)] = pat[63 - ((off + k) % 64)];
            end
            off += 32;
        end
        if (keep) begin
            idle_cs_n = 1'b0; frame_bits = off;
        end else begin
            repeat (hold_c + 1) expq.push_back(3'b000);
            repeat (gap_c + 1)  expq.push_back(3'b100);
            idle_cs_n = 1'b1; frame_bits = 0;
        end
        wr(4'd0, {23'd0, keep, 5'd0, r, w, 1'b1}, {req, " start"});
        rd(4'd7, v);
        check({req, " R12 end flag low after start"}, {31'd0, v[0]}, 32'd0);
        n = 0;
        while (expq.size() > 0) begin
            if (n == inject) begin
                reg_we = 1'b1; reg_addr = 4'd0; reg_wdata = 32'h0000_0105;
                tick({req, " R13 busy start"});
                reg_we = 1'b0;
            end else tick(req);
            n++;
        end
        tick({req, " idle"});
        rd(4'd7, v);
        check({req, " R12 status after end"}, v, {30'd0, keep, 1'b1});
    endtask

    initial begin
        repeat (4000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) tick("R1 reset pins");
        rst_n = 1'b1;
        tick("R1 pins after reset");
        rd(4'd7, v); check("R1 status reset", v, 32'd0);
        rd(4'd6, v); check("R1 read data reset", v, 32'd0);

        // full write transfer: R2 R3 R4 R5 R6 R7 R9 R10
        set_delays(2, 1, 3);
        m_cmd = 8'hA5;        wr(4'd2, {8'd0, m_cmd, 16'd0}, "R4 cmd write");
        m_addr = 24'h3C5A96;  wr(4'd3, {8'd0, m_addr}, "R5 addr write");
        m_dmy = 7;            wr(4'd4, 32'd7, "R6 dummy write");
        m_wdata = 32'h1122_8344; wr(4'd5, m_wdata, "R7 wdata write");
        set_phases(1, 1, 1, 1);
        xfer(1, 0, 0, -1, "R4 R5 R6 R7 R9 R10 full write");
        rd(4'd6, v); check("R8 read data untouched by write-only", v, exp_rdata);

        // full read transfer: R8
        xfer(0, 1, 0, -1, "R8 R7 full read");
        rd(4'd6, v); check("R8 read data byte order", v, exp_rdata);

        // command only, no data: R9
        set_phases(1, 0, 0, 0);
        xfer(1, 1, 0, -1, "R9 command only");

        // nothing enabled: R9
        set_phases(0, 0, 0, 0);
        xfer(1, 0, 0, -1, "R9 empty transfer");

        // address plus one dummy clock and read, zero delays: R5 R6 R10
        set_delays(0, 0, 0);
        m_dmy = 0; wr(4'd4, 32'd0, "R6 dummy write");
        set_phases(0, 1, 1, 1);
        xfer(0, 1, 0, -1, "R5 R6 R10 addr dummy read");
        rd(4'd6, v); check("R8 read after address", v, exp_rdata);

        // keep-select chain: R11
        set_delays(1, 2, 0);
        set_phases(1, 0, 0, 1);
        m_wdata = 32'hDEAD_0F01; wr(4'd5, m_wdata, "R11 wdata write");
        xfer(1, 0, 1, -1, "R11 first word");
        m_wdata = 32'h5A69_C3E2; wr(4'd5, m_wdata, "R11 wdata write held");
        xfer(1, 0, 1, -1, "R11 second word");
        xfer(0, 1, 0, -1, "R11 R8 last word read");
        rd(4'd6, v); check("R11 R8 read across held frame", v, exp_rdata);

        // start written while busy: R13
        set_phases(1, 1, 0, 1);
        xfer(1, 0, 0, 20, "R13 busy write");
        rd(4'd0, v); check("R13 control unchanged", v, 32'h0000_0002);
        rd(4'd6, v); check("R13 read data unchanged", v, exp_rdata);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule